// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block schedules the background memory reads of a tile-based video renderer over one scanline. It follows a dot counter (0 to 340) that the timing generator supplies. For every tile it reads four bytes, two dots per access: the name-table entry, the attribute byte, and the low and high pattern bytes. Each byte is held in an internal latch, and once every eight dots a reload strobe tells the downstream pixel shifter to take the latched tile.

During the visible part of a line it fetches 32 tiles. After a quiet gap it prefetches the first two tiles of the next line and then issues two trailing name-table reads whose data is thrown away. Address formation is simplified. The tile column comes from an internal tile-index counter, and the coarse and fine row come from inputs. The read port expects synchronous memory that returns data in the dot after the strobe.

Top module: `bg_tile_fetch`

## Requirements
- R1: In each eight-dot tile group starting at dot G, the read strobe is high on dot G with the name-table address, on G+2 with the attribute address, on G+4 with the low pattern address and on G+6 with the high pattern address. It is low on G+1, G+3, G+5 and G+7. The addresses are computed as follows:
  - Name-table address: 0x2000 + row*32 + tile.
  - Attribute address: 0x23C0 + (row/4)*8 + tile/4.
  - Low pattern address: name byte*16 + fine.
  - High pattern address: name byte*16 + 8 + fine.
- R2: The memory returns data in the dot after the strobe, and the block captures it at the end of that dot. From the next dot on, the pattern outputs show the low and high pattern bytes of the latest complete tile.
- R3: The attribute output carries bits [2q+1:2q] of the attribute byte, where q = 2*row[1] + tile[1].
- R4: The reload strobe is high for exactly one dot at dots 9, 17, …, 257, and at 329 and 337. It is low on every other dot.
- R5: The tile-index counter is 0 after reset. It is cleared at dot 320 and advances by one after each high pattern fetch, so visible groups at dots 1, 9, …, 249 use successive tiles.
- R6: During dots 257 to 320 the read strobe stays low.
- R7: Dots 321 to 336 fetch two tile groups, for tiles 0 and 1.
- R8: Name-table reads are issued at dots 337 and 339 with tile 2. They leave the attribute and pattern outputs unchanged.
- R9: While rendering is disabled or the line is inactive, no read strobe or reload strobe is issued, and the attribute and pattern outputs hold their values.
- R10: During reset the read and reload strobes are low and the attribute and pattern outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_i | input | 9 | Current dot of the scanline, 0 to 340 |
| line_active_i | input | 1 | Line takes part in background fetching |
| render_en_i | input | 1 | Background rendering enabled |
| row_i | input | 5 | Coarse tile row used for name-table and attribute addresses |
| fine_i | input | 3 | Pixel row within the tile |
| vram_rdata_i | input | 8 | Read data, valid in the dot after the strobe |
| vram_addr_o | output | 14 | Read address |
| vram_rd_o | output | 1 | Read strobe |
| reload_o | output | 1 | Shifter reload strobe |
| attr_o | output | 2 | Latched palette-select bits of the latest tile |
| pat_lo_o | output | 8 | Latched low pattern byte |
| pat_hi_o | output | 8 | Latched high pattern byte |

## Verification
The bench builds the block with its default parameters: 32 visible groups, a two-group prefetch starting at dot 321, and two trailing name-table reads. With these values a single scanline exercises every region of the line. That covers the first and last visible groups, the reload at 257 that falls in the quiet gap, the prefetch reloads, and the dummy reads that coincide with the final reload. A second line with another row reaches the upper attribute quadrant and the tile counter's continuation after the prefetch. Two disabled lines then cover the idle behaviour.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int GROUP_DOTS = 8;

  typedef enum logic [1:0] {
    FK_NAME = 2'd0,
    FK_ATTR = 2'd1,
    FK_PLO  = 2'd2,
    FK_PHI  = 2'd3
  } fetch_kind_e;

  typedef struct packed {
    logic        issue;
    logic        capture;
    fetch_kind_e kind;
    logic        reload;
  } dot_ctl_t;
endpackage

// File: rtl/bgf_dot_decode.sv
module bgf_dot_decode
  import bgf_pkg::*;
#(
  parameter int DOT_W       = 9,
  parameter int VIS_GROUPS  = 32,
  parameter int PREF_START  = 321,
  parameter int PREF_GROUPS = 2,
  parameter int DUMMY_COUNT = 2
) (
  input  logic [DOT_W-1:0] dot_i,
  input  logic             en_i,
  output dot_ctl_t         ctl_o
);
  localparam int VIS_END     = VIS_GROUPS * GROUP_DOTS;
  localparam int PREF_END    = PREF_START + PREF_GROUPS * GROUP_DOTS - 1;
  localparam int DUMMY_FIRST = PREF_END + 1;
  localparam int DUMMY_LAST  = PREF_END + 2 * DUMMY_COUNT;

  localparam logic [DOT_W-1:0] D_ONE        = DOT_W'(1);
  localparam logic [DOT_W-1:0] D_VIS_END    = DOT_W'(VIS_END);
  localparam logic [DOT_W-1:0] D_VRL_FIRST  = DOT_W'(1 + GROUP_DOTS);
  localparam logic [DOT_W-1:0] D_VRL_LAST   = DOT_W'(VIS_END + 1);
  localparam logic [DOT_W-1:0] D_PREF_START = DOT_W'(PREF_START);
  localparam logic [DOT_W-1:0] D_PREF_END   = DOT_W'(PREF_END);
  localparam logic [DOT_W-1:0] D_PRL_FIRST  = DOT_W'(PREF_START + GROUP_DOTS);
  localparam logic [DOT_W-1:0] D_PRL_LAST   = DOT_W'(PREF_END + 1);
  localparam logic [DOT_W-1:0] D_DUM_FIRST  = DOT_W'(DUMMY_FIRST);
  localparam logic [DOT_W-1:0] D_DUM_LAST   = DOT_W'(DUMMY_LAST);
  localparam logic [2:0]       PREF_PH0     = 3'(PREF_START);

  logic       in_vis, in_pref, win;
  logic [2:0] vis_ph, pref_ph, phase;
  logic       vis_reload, pref_reload, dummy_issue;

  always_comb begin
    in_vis      = (dot_i >= D_ONE) && (dot_i <= D_VIS_END);
    in_pref     = (dot_i >= D_PREF_START) && (dot_i <= D_PREF_END);
    vis_ph      = dot_i[2:0] - 3'd1;
    pref_ph     = dot_i[2:0] - PREF_PH0;
    phase       = in_vis ? vis_ph : pref_ph;
    win         = en_i && (in_vis || in_pref);
    vis_reload  = (dot_i >= D_VRL_FIRST) && (dot_i <= D_VRL_LAST) && (vis_ph == 3'd0);
    pref_reload = (dot_i >= D_PRL_FIRST) && (dot_i <= D_PRL_LAST) && (pref_ph == 3'd0);
  end

  generate
    if (DUMMY_COUNT > 0) begin : g_dummy
      assign dummy_issue = en_i && (dot_i >= D_DUM_FIRST) && (dot_i <= D_DUM_LAST)
                           && (dot_i[0] == D_DUM_FIRST[0]);
    end else begin : g_no_dummy
      assign dummy_issue = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl_o.issue   = (win && !phase[0]) || dummy_issue;
    ctl_o.capture = win && phase[0];
    ctl_o.kind    = dummy_issue ? FK_NAME : fetch_kind_e'(phase[2:1]);
    ctl_o.reload  = en_i && (vis_reload || pref_reload);
  end
endmodule

// File: rtl/bgf_tile_ctr.sv
module bgf_tile_ctr #(
  parameter int COL_W     = 5,
  parameter int DOT_W     = 9,
  parameter int CLEAR_DOT = 320
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DOT_W-1:0] dot_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] idx_o
);
  localparam logic [DOT_W-1:0] D_CLEAR = DOT_W'(CLEAR_DOT);

  logic clr;
  assign clr = (dot_i == D_CLEAR);

  always_ff @(posedge clk) begin
    if (rst || clr) idx_o <= '0;
    else if (adv_i) idx_o <= idx_o + COL_W'(1);
  end

  // R5
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !clr) |=> (idx_o == $past(idx_o) + COL_W'(1)));
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
  import bgf_pkg::*;
#(
  parameter int            ADDR_W = 14,
  parameter int            DATA_W = 8,
  parameter int            COL_W  = 5,
  parameter int            ROW_W  = 5,
  parameter int            FINE_W = 3,
  parameter logic [13:0]   NT_BASE  = 14'h2000,
  parameter logic [13:0]   AT_OFF   = 14'h03C0,
  parameter logic [13:0]   PAT_BASE = 14'h0000
) (
  input  fetch_kind_e       kind_i,
  input  logic [COL_W-1:0]  idx_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [FINE_W-1:0] fine_i,
  input  logic [DATA_W-1:0] name_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] A_NT  = ADDR_W'(NT_BASE);
  localparam logic [ADDR_W-1:0] A_AT  = ADDR_W'(NT_BASE + AT_OFF);
  localparam logic [ADDR_W-1:0] A_PAT = ADDR_W'(PAT_BASE);

  always_comb begin
    unique case (kind_i)
      FK_NAME: addr_o = A_NT + ADDR_W'({row_i, idx_i});
      FK_ATTR: addr_o = A_AT + ADDR_W'({row_i[ROW_W-1:2], idx_i[COL_W-1:2]});
      FK_PLO:  addr_o = A_PAT + ADDR_W'({name_i, 1'b0, fine_i});
      default: addr_o = A_PAT + ADDR_W'({name_i, 1'b1, fine_i});
    endcase
  end
endmodule

// File: rtl/bgf_fetch_latch.sv
module bgf_fetch_latch
  import bgf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  fetch_kind_e       kind_i,
  input  logic [1:0]        quad_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] name_o,
  output logic [1:0]        attr_o,
  output logic [DATA_W-1:0] plo_o,
  output logic [DATA_W-1:0] phi_o
);
  logic [1:0] attr_sel;
  assign attr_sel = rdata_i[{quad_i, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      name_o <= '0;
      attr_o <= '0;
      plo_o  <= '0;
      phi_o  <= '0;
    end else if (cap_i) begin
      unique case (kind_i)
        FK_NAME: name_o <= rdata_i;
        FK_ATTR: attr_o <= attr_sel;
        FK_PLO:  plo_o  <= rdata_i;
        default: phi_o  <= rdata_i;
      endcase
    end
  end

  // R2
  lo_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(plo_o) |-> $past(cap_i && kind_i == FK_PLO));

  // R2
  hi_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(phi_o) |-> $past(cap_i && kind_i == FK_PHI));
endmodule

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch
  import bgf_pkg::*;
#(
  parameter int DOT_W       = 9,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int ROW_W       = 5,
  parameter int FINE_W      = 3,
  parameter int VIS_GROUPS  = 32,
  parameter int PREF_START  = 321,
  parameter int PREF_GROUPS = 2,
  parameter int DUMMY_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              line_active_i,
  input  logic              render_en_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [FINE_W-1:0] fine_i,
  input  logic [DATA_W-1:0] vram_rdata_i,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic              vram_rd_o,
  output logic              reload_o,
  output logic [1:0]        attr_o,
  output logic [DATA_W-1:0] pat_lo_o,
  output logic [DATA_W-1:0] pat_hi_o
);
  localparam int COL_W = $clog2(VIS_GROUPS);
  localparam int HOLE_FIRST = VIS_GROUPS * GROUP_DOTS + 1;
  localparam int HOLE_LAST  = PREF_START - 1;
  localparam logic [DOT_W-1:0] D_HOLE_FIRST = DOT_W'(HOLE_FIRST);
  localparam logic [DOT_W-1:0] D_HOLE_LAST  = DOT_W'(HOLE_LAST);

  logic              fetch_en;
  dot_ctl_t          ctl;
  logic [COL_W-1:0]  tile_idx;
  logic [DATA_W-1:0] name_q;

  assign fetch_en = render_en_i && line_active_i && !rst;

  bgf_dot_decode #(
    .DOT_W(DOT_W), .VIS_GROUPS(VIS_GROUPS), .PREF_START(PREF_START),
    .PREF_GROUPS(PREF_GROUPS), .DUMMY_COUNT(DUMMY_COUNT)
  ) u_decode (
    .dot_i(dot_i), .en_i(fetch_en), .ctl_o(ctl)
  );

  bgf_tile_ctr #(
    .COL_W(COL_W), .DOT_W(DOT_W), .CLEAR_DOT(PREF_START - 1)
  ) u_ctr (
    .clk(clk), .rst(rst), .dot_i(dot_i),
    .adv_i(ctl.capture && ctl.kind == FK_PHI), .idx_o(tile_idx)
  );

  bgf_addr_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W),
    .ROW_W(ROW_W), .FINE_W(FINE_W)
  ) u_addr (
    .kind_i(ctl.kind), .idx_i(tile_idx), .row_i(row_i), .fine_i(fine_i),
    .name_i(name_q), .addr_o(vram_addr_o)
  );

  bgf_fetch_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .cap_i(ctl.capture), .kind_i(ctl.kind),
    .quad_i({row_i[1], tile_idx[1]}), .rdata_i(vram_rdata_i),
    .name_o(name_q), .attr_o(attr_o), .plo_o(pat_lo_o), .phi_o(pat_hi_o)
  );

  assign vram_rd_o = ctl.issue;
  assign reload_o  = ctl.reload;

  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    vram_rd_o |=> !vram_rd_o);

  // R4
  reload_gap_chk: assert property (@(posedge clk) disable iff (rst)
    reload_o |=> !reload_o);

  // R6
  gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (dot_i >= D_HOLE_FIRST && dot_i <= D_HOLE_LAST) |-> !vram_rd_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(render_en_i && line_active_i) |-> (!vram_rd_o && !reload_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!(render_en_i && line_active_i)) |-> ($stable(pat_lo_o) && $stable(pat_hi_o)
                                                && $stable(attr_o)));
endmodule

// File: tb/tb_bg_tile_fetch.sv
module tb_bg_tile_fetch;
  typedef struct packed {
    logic [8:0]  dot;
    logic        rd;
    logic        rl;
    logic [13:0] addr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{9'd0,   1'b0, 1'b0, 14'h0000}, '{9'd1,   1'b1, 1'b0, 14'h20A0},
    '{9'd2,   1'b0, 1'b0, 14'h0000}, '{9'd3,   1'b1, 1'b0, 14'h23C8},
    '{9'd4,   1'b0, 1'b0, 14'h0000}, '{9'd5,   1'b1, 1'b0, 14'h0FA3},
    '{9'd7,   1'b1, 1'b0, 14'h0FAB}, '{9'd8,   1'b0, 1'b0, 14'h0000},
    '{9'd9,   1'b1, 1'b1, 14'h20A1}, '{9'd10,  1'b0, 1'b0, 14'h0000},
    '{9'd11,  1'b1, 1'b0, 14'h23C8}, '{9'd33,  1'b1, 1'b1, 14'h20A4},
    '{9'd35,  1'b1, 1'b0, 14'h23C9}, '{9'd249, 1'b1, 1'b1, 14'h20BF},
    '{9'd251, 1'b1, 1'b0, 14'h23CF}, '{9'd253, 1'b1, 1'b0, 14'h0E53},
    '{9'd255, 1'b1, 1'b0, 14'h0E5B}, '{9'd256, 1'b0, 1'b0, 14'h0000},
    '{9'd257, 1'b0, 1'b1, 14'h0000}, '{9'd258, 1'b0, 1'b0, 14'h0000},
    '{9'd300, 1'b0, 1'b0, 14'h0000}, '{9'd320, 1'b0, 1'b0, 14'h0000},
    '{9'd321, 1'b1, 1'b0, 14'h20A0}, '{9'd328, 1'b0, 1'b0, 14'h0000},
    '{9'd329, 1'b1, 1'b1, 14'h20A1}, '{9'd336, 1'b0, 1'b0, 14'h0000},
    '{9'd337, 1'b1, 1'b1, 14'h20A2}, '{9'd338, 1'b0, 1'b0, 14'h0000},
    '{9'd339, 1'b1, 1'b0, 14'h20A2}, '{9'd340, 1'b0, 1'b0, 14'h0000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  dot;
  logic        line_active, render_en;
  logic [4:0]  row;
  logic [2:0]  fine;
  logic [7:0]  rdata = 8'h00;
  logic [13:0] addr;
  logic        rd, reload;
  logic [1:0]  attr;
  logic [7:0]  plo, phi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bg_tile_fetch dut (
    .clk(clk), .rst(rst), .dot_i(dot), .line_active_i(line_active),
    .render_en_i(render_en), .row_i(row), .fine_i(fine), .vram_rdata_i(rdata),
    .vram_addr_o(addr), .vram_rd_o(rd), .reload_o(reload), .attr_o(attr),
    .pat_lo_o(plo), .pat_hi_o(phi)
  );

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd) rdata <= mem_f(addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int d);
    @(posedge clk);
    #1 dot = d[8:0];
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [1:0] s_attr;
    logic [7:0] s_lo, s_hi;
    int n_rd, n_rl;
    rst = 1'b1; dot = 9'd1; line_active = 1'b1; render_en = 1'b1; row = 5'd5; fine = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state, even on a fetch dot
    chk("R10 rd", 32'(rd), 0);
    chk("R10 reload", 32'(reload), 0);
    chk("R10 attr", 32'(attr), 0);
    chk("R10 lo", 32'(plo), 0);
    chk("R10 hi", 32'(phi), 0);
    @(posedge clk);
    #1 rst = 1'b0; dot = 9'd0;

    // Line 1: vector table walk (R1 R4 R5 R6 R7 R8)
    s_attr = '0; s_lo = '0; s_hi = '0;
    for (int d = 0; d <= 340; d++) begin
      step(d);
      for (int k = 0; k < NV; k++) begin
        if (int'(TBL[k].dot) == d) begin
          chk("R1/R4/R6 rd", 32'(rd), 32'(TBL[k].rd));
          chk("R4 reload", 32'(reload), 32'(TBL[k].rl));
          if (TBL[k].rd) chk("R1/R5/R7/R8 addr", 32'(addr), 32'(TBL[k].addr));
        end
      end
      if (d == 9) begin
        // R2 tile 0 latched before first reload
        chk("R2 lo", 32'(plo), 32'(mem_f(14'h0FA3)));
        chk("R2 hi", 32'(phi), 32'(mem_f(14'h0FAB)));
        chk("R3 attr q0", 32'(attr), 32'(mem_f(14'h23C8) & 8'h03));
      end
      if (d == 337) begin
        s_attr = attr; s_lo = plo; s_hi = phi;
        chk("R7 prefetch lo", 32'(plo), 32'(mem_f({2'b00, mem_f(14'h20A1), 1'b0, 3'd3})));
      end
      if (d == 340) begin
        // R8 dummy reads leave latches alone
        chk("R8 lo", 32'(plo), 32'(s_lo));
        chk("R8 hi", 32'(phi), 32'(s_hi));
        chk("R8 attr", 32'(attr), 32'(s_attr));
      end
    end

    // Line 2: row 7, counter continues at tile 2 (R5), upper quadrant (R3)
    row = 5'd7;
    n_rd = 0; n_rl = 0;
    for (int d = 0; d <= 340; d++) begin
      step(d);
      if (rd) n_rd++;
      if (reload) n_rl++;
      if (d == 1) chk("R5 tile 2 after prefetch", 32'(addr), 32'h20E2);
      if (d == 9) begin
        chk("R3 attr q3", 32'(attr), 32'((mem_f(14'h23C8) >> 6) & 8'h03));
        chk("R2 lo row7", 32'(plo), 32'(mem_f({2'b00, mem_f(14'h20E2), 1'b0, 3'd3})));
      end
    end
    chk("R1 read count", 32'(n_rd), 138);
    chk("R4 reload count", 32'(n_rl), 34);

    // Line 3: rendering disabled (R9)
    s_attr = attr; s_lo = plo; s_hi = phi;
    render_en = 1'b0;
    n_rd = 0; n_rl = 0;
    for (int d = 0; d <= 340; d++) begin
      step(d);
      if (rd) n_rd++;
      if (reload) n_rl++;
    end
    chk("R9 disabled reads", 32'(n_rd), 0);
    chk("R9 disabled reloads", 32'(n_rl), 0);
    chk("R9 disabled lo", 32'(plo), 32'(s_lo));
    chk("R9 disabled hi", 32'(phi), 32'(s_hi));
    chk("R9 disabled attr", 32'(attr), 32'(s_attr));

    // Line 4: line inactive (R9)
    render_en = 1'b1; line_active = 1'b0;
    n_rd = 0; n_rl = 0;
    for (int d = 0; d <= 340; d++) begin
      step(d);
      if (rd) n_rd++;
      if (reload) n_rl++;
    end
    chk("R9 inactive reads", 32'(n_rd), 0);
    chk("R9 inactive reloads", 32'(n_rl), 0);
    chk("R9 inactive lo", 32'(plo), 32'(s_lo));

    finish_run();
  end
endmodule